// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a shared 32-bit address/data bus together with its 4-bit command/byte-enable lines, for a device that can be either the initiator or the target of a bus transfer. Each clock it looks at the device's role, the bus phase and the transfer direction. It then decides whether the device owns the parity line in the next clock, in which case it drives the computed bit. Otherwise it compares the incoming parity bit against its own calculation.

The parity line always carries the parity of the bus values from the previous clock. A detected mismatch is reported two clocks after the phase it belongs to. The report comes as a one-clock address-error or data-error pulse, and it sets a sticky detected-error bit that is cleared by writing 1. A data error is also signalled on the active-low data parity error line, but only when the parity-error-response enable is 1. When the device is initiator of a write, the block samples the incoming error line to learn whether the target saw bad data.

Top module: `pci_parity_unit`

## Requirements
- R1: One clock after a cycle in which the block generates parity, `par_o` holds the bit that makes the count of ones in {ad_i, cbe_i, par_o} of that earlier cycle even.
- R2: `par_oe_o` is 1 in the clock after a cycle where: initiator and address phase; or initiator, data phase and write; or target, data phase and read. It is 1 in the data-phase cases whatever the ready signals are, and 0 after every other cycle.
- R3: Parity is compared in exactly three cases. The first is an address phase while target. The second is a completed data phase that is an initiator read. The third is a completed data phase that is a target write. The comparison takes place in the next clock, using `par_i` of that clock.
- R4: A data phase is complete only in a clock where `irdy_i` and `trdy_i` are both 1. Incomplete data phases are never checked.
- R5: For a data mismatch found while `perr_resp_en_i` is 1, `perr_n_o` is 0 and `perr_oe_o` is 1 for exactly one clock, two clocks after the data phase. Otherwise `perr_n_o` stays 1 and `perr_oe_o` stays 0, and address mismatches never drive it.
- R6: `addr_perr_o` or `data_perr_o` pulses for one clock, two clocks after the phase, on a mismatch of that kind, whatever the value of `perr_resp_en_i`.
- R7: `detected_perr_o` is set by any mismatch and holds until `stat_clr_i` is 1. When a set and a clear fall in the same clock, the set wins.
- R8: After a completed initiator write data phase in clock N, `perr_n_i` low in clock N+2 makes `tgt_perr_o` 1 in clock N+3 only.
- R9: During and right after reset, `par_oe_o`, `perr_oe_o`, all error flags and the sticky bit are 0, and `perr_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Address/data bus as seen at the pins |
| cbe_i | input | 4 | Command/byte-enable lines as seen at the pins |
| is_master_i | input | 1 | 1 when this device is the initiator of the current transfer |
| addr_phase_i | input | 1 | Current clock is an address phase |
| data_phase_i | input | 1 | Current clock is inside a data phase |
| write_i | input | 1 | Current transfer is a write |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| par_i | input | 1 | Parity line as seen at the pin |
| par_o | output | 1 | Parity bit to drive |
| par_oe_o | output | 1 | Enable for driving the parity line |
| perr_resp_en_i | input | 1 | Parity-error-response enable from the command register |
| perr_n_i | input | 1 | Data parity error line as seen at the pin, active low |
| perr_n_o | output | 1 | Data parity error value to drive, active low |
| perr_oe_o | output | 1 | Enable for driving the data parity error line |
| stat_clr_i | input | 1 | Write-1 clear of the sticky detected-error bit |
| addr_perr_o | output | 1 | One-clock pulse on an address parity mismatch |
| data_perr_o | output | 1 | One-clock pulse on a data parity mismatch |
| detected_perr_o | output | 1 | Sticky detected-parity-error status |
| tgt_perr_o | output | 1 | One-clock pulse when a target reports an error on this device's write |

## Verification
The bench crosses role, phase kind, direction, both ready signals, the response enable, a good or corrupted incoming parity bit and a target error report, using all-zero, all-one, walking-bit and random bus values. It targets several classes of bug. Swapping the read/write sense of generation would enable the parity driver in the wrong phases. Ignoring one ready signal would flag errors on wait states. An ungated error line would pull `perr_n_o` low with reporting disabled or on an address error. A clear that beats a simultaneous set would lose an error. Sampling the target's error line one clock off would miss or misplace `tgt_perr_o`.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Qualifiers decided for one bus clock.
  typedef struct packed {
    logic drive;     // this device owns the parity line next clock
    logic chk_addr;  // address phase to be checked next clock
    logic chk_data;  // completed data phase to be checked next clock
    logic mst_wr;    // completed data phase of own write
  } phase_qual_t;

  localparam phase_qual_t QUAL_IDLE = '{drive: 1'b0, chk_addr: 1'b0,
                                        chk_data: 1'b0, mst_wr: 1'b0};

endpackage

// File: rtl/pci_par_qualify.sv
module pci_par_qualify
  import pci_par_pkg::*;
(
  input  logic        is_master_i,
  input  logic        addr_phase_i,
  input  logic        data_phase_i,
  input  logic        write_i,
  input  logic        irdy_i,
  input  logic        trdy_i,
  output phase_qual_t qual_o,
  output logic        complete_o
);

  // Data moves only when both sides are ready.
  function automatic logic xfer_done(input logic dphase, input logic ir,
                                     input logic tr);
    return dphase & ir & tr;
  endfunction

  // The side that drives the bus drives parity: initiator on writes,
  // target on reads.
  function automatic logic owns_data(input logic mst, input logic wr);
    return mst ? wr : ~wr;
  endfunction

  always_comb begin
    complete_o      = xfer_done(data_phase_i, irdy_i, trdy_i);
    qual_o          = QUAL_IDLE;
    qual_o.drive    = (is_master_i & addr_phase_i)
                    | (data_phase_i & owns_data(is_master_i, write_i));
    qual_o.chk_addr = ~is_master_i & addr_phase_i;
    qual_o.chk_data = complete_o & ~owns_data(is_master_i, write_i);
    qual_o.mst_wr   = complete_o & is_master_i & write_i;
  end

endmodule

// File: rtl/pci_par_pipe.sv
module pci_par_pipe
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  phase_qual_t      qual_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             mis_addr_o,
  output logic             mis_data_o,
  output logic             mst_wr_o
);

  localparam int BUS_W = AD_W + CBE_W;

  // Even parity: the bit that makes the total count of ones even.
  function automatic logic even_par(input logic [BUS_W-1:0] v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < BUS_W; i++) p = p ^ v[i];
    return p;
  endfunction

  phase_qual_t qual_q;
  logic        par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_q <= QUAL_IDLE;
      par_q  <= 1'b0;
    end else begin
      qual_q <= qual_i;
      par_q  <= even_par({cbe_i, ad_i});
    end
  end

  assign par_o      = par_q;
  assign par_oe_o   = qual_q.drive;
  assign mis_addr_o = qual_q.chk_addr & (par_i ^ par_q);
  assign mis_data_o = qual_q.chk_data & (par_i ^ par_q);
  assign mst_wr_o   = qual_q.mst_wr;

endmodule

// File: rtl/pci_par_report.sv
module pci_par_report (
  input  logic clk,
  input  logic rst_n,
  input  logic mis_addr_i,
  input  logic mis_data_i,
  input  logic perr_resp_en_i,
  input  logic mst_wr_i,
  input  logic perr_n_i,
  input  logic stat_clr_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic addr_perr_o,
  output logic data_perr_o,
  output logic detected_perr_o,
  output logic tgt_perr_o
);

  logic addr_q, data_q, drv_q, sticky_q, mw_q, tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= 1'b0;
      data_q   <= 1'b0;
      drv_q    <= 1'b0;
      sticky_q <= 1'b0;
      mw_q     <= 1'b0;
      tgt_q    <= 1'b0;
    end else begin
      addr_q   <= mis_addr_i;
      data_q   <= mis_data_i;
      drv_q    <= mis_data_i & perr_resp_en_i;
      // A new error outranks a clear in the same clock.
      sticky_q <= mis_addr_i | mis_data_i | (sticky_q & ~stat_clr_i);
      mw_q     <= mst_wr_i;
      tgt_q    <= mw_q & ~perr_n_i;
    end
  end

  assign perr_n_o        = ~drv_q;
  assign perr_oe_o       = drv_q;
  assign addr_perr_o     = addr_q;
  assign data_perr_o     = data_q;
  assign detected_perr_o = sticky_q;
  assign tgt_perr_o      = tgt_q;

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             is_master_i,
  input  logic             addr_phase_i,
  input  logic             data_phase_i,
  input  logic             write_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  input  logic             perr_resp_en_i,
  input  logic             perr_n_i,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  input  logic             stat_clr_i,
  output logic             addr_perr_o,
  output logic             data_perr_o,
  output logic             detected_perr_o,
  output logic             tgt_perr_o
);

  // Named internal events, visible to the bound checker.
  phase_qual_t qual_now;
  logic        complete_now;
  logic        mis_addr_now;
  logic        mis_data_now;
  logic        mst_wr_now;

  pci_par_qualify u_qualify (
    .is_master_i  (is_master_i),
    .addr_phase_i (addr_phase_i),
    .data_phase_i (data_phase_i),
    .write_i      (write_i),
    .irdy_i       (irdy_i),
    .trdy_i       (trdy_i),
    .qual_o       (qual_now),
    .complete_o   (complete_now)
  );

  pci_par_pipe #(.AD_W(AD_W), .CBE_W(CBE_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .qual_i     (qual_now),
    .par_i      (par_i),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o),
    .mis_addr_o (mis_addr_now),
    .mis_data_o (mis_data_now),
    .mst_wr_o   (mst_wr_now)
  );

  pci_par_report u_report (
    .clk             (clk),
    .rst_n           (rst_n),
    .mis_addr_i      (mis_addr_now),
    .mis_data_i      (mis_data_now),
    .perr_resp_en_i  (perr_resp_en_i),
    .mst_wr_i        (mst_wr_now),
    .perr_n_i        (perr_n_i),
    .stat_clr_i      (stat_clr_i),
    .perr_n_o        (perr_n_o),
    .perr_oe_o       (perr_oe_o),
    .addr_perr_o     (addr_perr_o),
    .data_perr_o     (data_perr_o),
    .detected_perr_o (detected_perr_o),
    .tgt_perr_o      (tgt_perr_o)
  );

endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_i,
  input logic [CBE_W-1:0] cbe_i,
  input logic             is_master_i,
  input logic             addr_phase_i,
  input logic             data_phase_i,
  input logic             write_i,
  input logic             irdy_i,
  input logic             trdy_i,
  input logic             par_o,
  input logic             par_oe_o,
  input logic             perr_resp_en_i,
  input logic             perr_n_i,
  input logic             perr_n_o,
  input logic             perr_oe_o,
  input logic             addr_perr_o,
  input logic             data_perr_o,
  input logic             detected_perr_o,
  input logic             tgt_perr_o,
  input logic             mis_addr_now,
  input logic             mis_data_now,
  input logic             mst_wr_now
);

  assert_gen_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master_i && addr_phase_i) |=> (par_o == ^$past({cbe_i, ad_i})));

  assert_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase_i && !data_phase_i) |=> !par_oe_o);

  assert_target_addr_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master_i && addr_phase_i) |=> !par_oe_o);

  assert_incomplete_unchecked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase_i && !(irdy_i && trdy_i)) |=> !mis_data_now && !mis_addr_now);

  assert_perr_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_data_now && perr_resp_en_i) |=> (!perr_n_o && perr_oe_o));

  assert_perr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mis_data_now || !perr_resp_en_i) |=> (perr_n_o && !perr_oe_o));

  assert_addr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mis_addr_now |=> (addr_perr_o && !data_perr_o));

  assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_addr_now || mis_data_now) |=> detected_perr_o);

  assert_tgt_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_perr_o |-> ($past(perr_n_i) == 1'b0));

  assert_tgt_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mst_wr_now |=> ##1 (tgt_perr_o == !$past(perr_n_i)));

endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ad_i            (ad_i),
  .cbe_i           (cbe_i),
  .is_master_i     (is_master_i),
  .addr_phase_i    (addr_phase_i),
  .data_phase_i    (data_phase_i),
  .write_i         (write_i),
  .irdy_i          (irdy_i),
  .trdy_i          (trdy_i),
  .par_o           (par_o),
  .par_oe_o        (par_oe_o),
  .perr_resp_en_i  (perr_resp_en_i),
  .perr_n_i        (perr_n_i),
  .perr_n_o        (perr_n_o),
  .perr_oe_o       (perr_oe_o),
  .addr_perr_o     (addr_perr_o),
  .data_perr_o     (data_perr_o),
  .detected_perr_o (detected_perr_o),
  .tgt_perr_o      (tgt_perr_o),
  .mis_addr_now    (mis_addr_now),
  .mis_data_now    (mis_data_now),
  .mst_wr_now      (mst_wr_now)
);

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        is_master_i = 1'b0, addr_phase_i = 1'b0, data_phase_i = 1'b0;
  logic        write_i = 1'b0, irdy_i = 1'b0, trdy_i = 1'b0, par_i = 1'b0;
  logic        perr_resp_en_i = 1'b0, perr_n_i = 1'b1, stat_clr_i = 1'b0;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o;
  logic        addr_perr_o, data_perr_o, detected_perr_o, tgt_perr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_parity_unit u_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i),
    .is_master_i(is_master_i), .addr_phase_i(addr_phase_i),
    .data_phase_i(data_phase_i), .write_i(write_i), .irdy_i(irdy_i),
    .trdy_i(trdy_i), .par_i(par_i), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_resp_en_i(perr_resp_en_i), .perr_n_i(perr_n_i),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .stat_clr_i(stat_clr_i),
    .addr_perr_o(addr_perr_o), .data_perr_o(data_perr_o),
    .detected_perr_o(detected_perr_o), .tgt_perr_o(tgt_perr_o)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Parity computed by counting ones: odd count -> parity bit 1.
  function automatic logic count_par(input logic [31:0] a, input logic [3:0] c);
    int ones;
    ones = 0;
    for (int i = 0; i < 32; i++) if (a[i]) ones++;
    for (int i = 0; i < 4; i++) if (c[i]) ones++;
    return (ones % 2) == 1;
  endfunction

  task automatic go_idle();
    addr_phase_i = 1'b0; data_phase_i = 1'b0;
    irdy_i = 1'b0; trdy_i = 1'b0;
  endtask

  // kind: 0 idle, 1 address phase, 2 data phase
  task automatic scenario(input bit m, input int kind, input bit w,
                          input bit ir, input bit tr, input bit en,
                          input bit bad, input bit te,
                          input logic [31:0] a, input logic [3:0] c);
    logic p;
    bit   drive, comp, chka, chkd, aerr, derr, mw;
    p     = count_par(a, c);
    comp  = (kind == 2) && ir && tr;
    if (kind == 1) drive = m;
    else if (kind == 2) drive = (m && w) || (!m && !w);
    else drive = 1'b0;
    chka  = (kind == 1) && !m;
    chkd  = comp && (m != w);
    aerr  = chka && bad;
    derr  = chkd && bad;
    mw    = comp && m && w;
    // clock N
    ad_i = a; cbe_i = c; is_master_i = m; write_i = w;
    addr_phase_i = (kind == 1); data_phase_i = (kind == 2);
    irdy_i = ir; trdy_i = tr; perr_resp_en_i = en;
    @(posedge clk); #1;
    // clock N+1
    check("R2", "par_oe_o", par_oe_o, drive);
    if (drive) check("R1", "par_o", par_o, p);
    go_idle();
    ad_i = ~a; cbe_i = ~c;
    par_i = p ^ bad;
    stat_clr_i = 1'b1;
    @(posedge clk); #1;
    // clock N+2
    check(kind == 2 ? "R4" : "R3", "addr_perr_o", addr_perr_o, aerr);
    check(kind == 2 ? "R4" : "R3", "data_perr_o", data_perr_o, derr);
    check("R5", "perr_n_o", perr_n_o, !(derr && en));
    check("R5", "perr_oe_o", perr_oe_o, derr && en);
    check("R7", "detected_perr_o set wins", detected_perr_o, aerr || derr);
    stat_clr_i = 1'b0;
    perr_n_i = !te;
    @(posedge clk); #1;
    // clock N+3
    check("R8", "tgt_perr_o", tgt_perr_o, mw && te);
    check("R6", "addr_perr_o pulse", addr_perr_o, 1'b0);
    check("R6", "data_perr_o pulse", data_perr_o, 1'b0);
    check("R5", "perr_n_o released", perr_n_o, 1'b1);
    check("R7", "detected_perr_o held", detected_perr_o, aerr || derr);
    perr_n_i = 1'b1;
    stat_clr_i = 1'b1;
    @(posedge clk); #1;
    // clock N+4
    stat_clr_i = 1'b0;
    check("R7", "detected_perr_o cleared", detected_perr_o, 1'b0);
    check("R8", "tgt_perr_o pulse", tgt_perr_o, 1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", "par_oe_o reset", par_oe_o, 1'b0);
    check("R9", "perr_n_o reset", perr_n_o, 1'b1);
    check("R9", "perr_oe_o reset", perr_oe_o, 1'b0);
    check("R9", "detected_perr_o reset", detected_perr_o, 1'b0);
    check("R9", "flags reset", addr_perr_o | data_perr_o | tgt_perr_o, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9", "par_oe_o after reset", par_oe_o, 1'b0);
    begin
      int n;
      logic [31:0] a;
      logic [3:0]  c;
      n = 0;
      for (int m = 0; m < 2; m++)
        for (int kind = 0; kind < 3; kind++)
          for (int w = 0; w < 2; w++)
            for (int ir = 0; ir < 2; ir++)
              for (int tr = 0; tr < 2; tr++)
                for (int en = 0; en < 2; en++)
                  for (int bad = 0; bad < 2; bad++)
                    for (int te = 0; te < 2; te++) begin
                      case (n % 4)
                        0: begin a = 32'h0; c = 4'h0; end
                        1: begin a = 32'hFFFF_FFFF; c = 4'hF; end
                        2: begin a = 32'h1 << (n % 32); c = 4'h1 << (n % 4); end
                        default: begin a = $urandom; c = 4'($urandom); end
                      endcase
                      n++;
                      scenario(m[0], kind, w[0], ir[0], tr[0], en[0],
                               bad[0], te[0], a, c);
                    end
    end
    summary();
  end

endmodule